// File: doc/BRIEF.md
# Banked Per-Core Timer Array

This block gathers one private countdown timer for each processor core, from one up to four cores, behind a single register request port. Requests are steered by address into 0x20-byte windows. Window 0 is an alias: it reaches the timer owned by whichever core issued the request, as named by the core-ID field that travels with the request. Each further window, from 1 up to the core count, is wired permanently to one core's timer. Every window presents the same four-register layout. Each timer drives its own interrupt line.

Requests use a valid/ready handshake. `req_ready` is low while reset is asserted and high at all other times, so a request transfers on any edge where `req_valid` is high after reset. A response comes back on the edge after the transfer and has no ready. `rsp_valid` is high for exactly one cycle, and the consumer must take `rsp_rdata` and `rsp_err` in that cycle. Illegal requests still complete. They return zero data and raise `rsp_err` for that one response cycle. The core count is a parameter, and a count outside 1 to 4 stops elaboration.

Top module: `banked_timer_array`

## Requirements
- R1: A request to window 0 (address bits [7:5] equal to 0) reaches the timer of the core named on `req_core`. Its reads and writes are the same as those made through that core's fixed window.
- R2: Window k+1 reaches the timer of core k, for k from 0 to N_CORES-1. A write through one window changes no other core's timer.
- R3: The register offsets inside a window are as follows.
  - 0x0 is the reload value. Writing it also writes the current count.
  - 0x4 is the current count.
  - 0x8 is control: bit 0 enables counting, bit 1 selects auto-reload, bits [15:8] hold the prescale value, and all other bits read as zero.
  - 0xC is status. Bit 0 is the expiry flag, and writing 1 to it clears it.
  - Offsets 0x10 to 0x1C read as zero.
- R4: A window-0 request with `req_core` >= N_CORES is an error. Its response carries zero data and `rsp_err`=1, and no timer changes. `rsp_err` stays high for that single response cycle only.
- R5: A request with `req_size` other than 2 (2 means 32 bits) is an error, and so is one with address bits [1:0] non-zero. It is handled in the same way as R4.
- R6: A request to a window above N_CORES reads zero. A write to such a window changes no timer, and neither case is an error.
- R7: `req_ready` is low during reset and high afterwards. Each transferred request produces exactly one response, with `rsp_valid` high on the following cycle. The read data is the value the addressed register held before that request took effect.
- R8: Counting starts when control bit 0 goes from 0 to 1 with count C>0 and prescale P. The status flag then sets exactly C*(P+1) cycles after the enabling write's edge.
- R9: On expiry with auto-reload set, the count reloads from the reload value and counting continues. Without auto-reload, the count stays at zero.
- R10: When a status-clear write lands in the same cycle as an expiry, the expiry wins and the flag ends up set.
- R11: Enabling with auto-reload while the count is zero first copies the reload value into the count.
- R12: `irq[k]` follows the status flag of core k, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: window in [ADDR_W-1:5], register in [4:2] |
| req_size | input | 2 | Access width code, 2 = 32 bits |
| req_core | input | 2 | ID of the requesting core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_rdata | output | 32 | Read data, zero on error |
| rsp_err | output | 1 | Illegal request flag |
| irq | output | N_CORES | Interrupt per core, bit k for core k |

## Verification
A write that clears a timer's status can meet that same timer's expiry on one clock edge. The bench provokes this by counting cycles from the enabling write and presenting the clear so that it transfers on exactly the expiry edge. It judges the outcome on the interrupt line, which must stay high. A second clear on a quiet cycle must then drop it.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int WORD_W    = 32;
  localparam int CORE_ID_W = 2;
  localparam int MAX_CORES = 4;
  localparam int WIN_SHIFT = 5;
  localparam int OFF_W     = 3;
  localparam int PRESC_W   = 8;

  localparam logic [1:0]       SIZE_WORD = 2'd2;
  localparam logic [OFF_W-1:0] OFF_RELOAD = 3'd0;
  localparam logic [OFF_W-1:0] OFF_COUNT  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_STAT   = 3'd3;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               autoload;
    logic               run;
  } tmr_ctrl_t;
endpackage

// File: rtl/bta_decode.sv
module bta_decode
  import bta_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [CORE_ID_W-1:0] req_core,
  output logic [N_CORES-1:0]   sel,
  output logic [OFF_W-1:0]     off,
  output logic                 err
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [WIN_W-1:0] win;
  logic             alias_hit;
  logic             bad_fmt;
  logic             bad_core;

  assign win       = req_addr[ADDR_W-1:WIN_SHIFT];
  assign off       = req_addr[WIN_SHIFT-1:2];
  assign alias_hit = (win == '0);
  assign bad_fmt   = (req_size != SIZE_WORD) || (req_addr[1:0] != 2'b00);
  assign bad_core  = alias_hit && (int'(req_core) >= N_CORES);
  assign err       = bad_fmt || bad_core;

  always_comb begin
    sel = '0;
    for (int k = 0; k < N_CORES; k++) begin
      if (!err) begin
        if (alias_hit && (req_core == CORE_ID_W'(k)))
          sel[k] = 1'b1;
        else if (win == WIN_W'(k + 1))
          sel[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bta_timer.sv
module bta_timer
  import bta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  tmr_ctrl_t          ctrl_q;
  logic [WORD_W-1:0]  reload_q;
  logic [WORD_W-1:0]  count_q;
  logic [PRESC_W-1:0] pre_q;
  logic               flag_q;

  logic wr_reload, wr_count, wr_ctrl, wr_stat;
  logic start, running, step, expire;

  assign wr_reload = wr_en && (off == OFF_RELOAD);
  assign wr_count  = wr_en && (off == OFF_COUNT);
  assign wr_ctrl   = wr_en && (off == OFF_CTRL);
  assign wr_stat   = wr_en && (off == OFF_STAT);

  assign start   = wr_ctrl && !ctrl_q.run && wdata[0];
  assign running = ctrl_q.run && (count_q != '0);
  assign step    = running && (pre_q >= ctrl_q.presc);
  // a direct count write overrides the tick that would have expired
  assign expire  = step && (count_q == WORD_W'(1)) && !wr_reload && !wr_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      count_q  <= '0;
      pre_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q.presc    <= wdata[15:8];
        ctrl_q.autoload <= wdata[1];
        ctrl_q.run      <= wdata[0];
      end

      if (wr_reload || wr_count) begin
        count_q <= wdata;
        pre_q   <= '0;
      end else if (start) begin
        pre_q <= '0;
        if ((count_q == '0) && wdata[1]) count_q <= reload_q;
      end else if (step) begin
        pre_q <= '0;
        if (count_q == WORD_W'(1))
          count_q <= ctrl_q.autoload ? reload_q : '0;
        else
          count_q <= count_q - WORD_W'(1);
      end else if (running) begin
        pre_q <= pre_q + PRESC_W'(1);
      end

      // expiry takes precedence over a clear landing on the same edge
      if (expire)                   flag_q <= 1'b1;
      else if (wr_stat && wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (off)
      OFF_RELOAD: rdata = reload_q;
      OFF_COUNT:  rdata = count_q;
      OFF_CTRL:   rdata = {16'h0, ctrl_q.presc, 6'h0, ctrl_q.autoload, ctrl_q.run};
      OFF_STAT:   rdata = {31'h0, flag_q};
      default:    rdata = '0;
    endcase
  end

  assign irq = flag_q;
endmodule

// File: rtl/bta_rsp.sv
module bta_rsp
  import bta_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              err,
  input  logic [N_CORES-1:0] sel,
  input  logic [WORD_W-1:0] tmr_rdata [N_CORES],
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic [WORD_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int k = 0; k < N_CORES; k++)
      picked = picked | (tmr_rdata[k] & {WORD_W{sel[k]}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= fire;
      rsp_err   <= fire && err;
      rsp_rdata <= fire ? picked : '0;
    end
  end
endmodule

// File: rtl/banked_timer_array.sv
module banked_timer_array
  import bta_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [CORE_ID_W-1:0] req_core,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [WORD_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic [N_CORES-1:0]   irq
);
  if (N_CORES < 1 || N_CORES > MAX_CORES) begin : g_bad_cores
    $error("banked_timer_array: N_CORES must lie in 1..4");
  end
  if ((1 << (ADDR_W - WIN_SHIFT)) < N_CORES + 1) begin : g_bad_addr
    $error("banked_timer_array: ADDR_W too small for the window count");
  end

  logic               ready_q;
  logic               fire;
  logic               err;
  logic [N_CORES-1:0] sel;
  logic [N_CORES-1:0] wr_sel;
  logic [OFF_W-1:0]   off;
  logic [WORD_W-1:0]  tmr_rdata [N_CORES];

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;
  assign wr_sel    = sel & {N_CORES{fire && req_write}};

  bta_decode #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_decode (
    .req_addr (req_addr),
    .req_size (req_size),
    .req_core (req_core),
    .sel      (sel),
    .off      (off),
    .err      (err)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    bta_timer u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_sel[k]),
      .off   (off),
      .wdata (req_wdata),
      .rdata (tmr_rdata[k]),
      .irq   (irq[k])
    );
  end

  bta_rsp #(.N_CORES(N_CORES)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .err       (err),
    .sel       (sel),
    .tmr_rdata (tmr_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/banked_timer_array_chk.sv
module banked_timer_array_chk #(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [1:0]        req_core,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err
);
  localparam int WIN_W = ADDR_W - 5;

  logic             fire;
  logic             fmt_ok;
  logic [WIN_W-1:0] win;

  assign fire   = req_valid && req_ready;
  assign fmt_ok = (req_size == 2'd2) && (req_addr[1:0] == 2'b00);
  assign win    = req_addr[ADDR_W-1:5];

  a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  a_r7_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
  a_r4_err_inside_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && (rsp_rdata == 32'h0));
  a_r4_bad_core_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (win == '0) && (int'(req_core) >= N_CORES)) |=> rsp_err);
  a_r5_bad_format_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !fmt_ok) |=> rsp_err);
  a_r6_beyond_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fmt_ok && (int'(win) > N_CORES)) |=> !rsp_err && (rsp_rdata == 32'h0));
endmodule

bind banked_timer_array banked_timer_array_chk #(.N_CORES(N_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_core  (req_core),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/banked_timer_array_bench.sv
module banked_timer_array_bench;
  localparam int NC = 3;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [1:0]    req_size  = 2'd2;
  logic [1:0]    req_core  = 2'd0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  banked_timer_array #(.N_CORES(NC), .ADDR_W(AW)) u_banked_timer_array (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_core(req_core), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ra(input int w, input int o);
    return 8'((w << 5) | (o << 2));
  endfunction

  // starts and ends at a falling edge; the request transfers on the edge between
  task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [1:0] core, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_size = sz; req_core = core; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(rsp_valid === 1'b1, "R7 response one cycle later", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic wr_reg(input int w, input int o, input logic [1:0] core,
                        input logic [31:0] d, input string tag);
    logic [31:0] rd; logic er;
    access(1'b1, ra(w, o), 2'd2, core, d, rd, er);
    chk(er === 1'b0, tag, 32'(er), 32'd0);
  endtask

  task automatic rd_reg(input int w, input int o, input logic [1:0] core,
                        input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic er;
    access(1'b0, ra(w, o), 2'd2, core, 32'h0, rd, er);
    chk(er === 1'b0 && rd === exp, tag, rd, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0, "R7 ready low in reset", 32'(req_ready), 32'd0);
    chk(irq === '0, "R12 irq low in reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready high after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R7 no response without request", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < NC; k++) wr_reg(k + 1, 0, 2'd0, 32'h100 + 32'(k), "R2 fixed write");
    for (int k = 0; k < NC; k++) rd_reg(k + 1, 0, 2'd0, 32'h100 + 32'(k), "R2 fixed reload readback");
    for (int k = 0; k < NC; k++) rd_reg(k + 1, 1, 2'd0, 32'h100 + 32'(k), "R3 reload write sets count");
    rd_reg(2, 3, 2'd0, 32'h0, "R3 status clear after reset");
    rd_reg(2, 5, 2'd0, 32'h0, "R3 unused offset reads zero");
    wr_reg(3, 2, 2'd0, 32'hABCD_F002, "R3 control write");
    rd_reg(3, 2, 2'd0, 32'h0000_F002, "R3 control field layout");
    wr_reg(3, 2, 2'd0, 32'h0, "R3 control clear");
  endtask

  task automatic t_alias;
    for (int k = 0; k < NC; k++) wr_reg(0, 0, 2'(k), 32'hA0 + 32'(k), "R1 alias write");
    for (int k = 0; k < NC; k++) rd_reg(k + 1, 0, 2'd0, 32'hA0 + 32'(k), "R1 alias reached own core");
    rd_reg(0, 0, 2'd2, 32'hA2, "R1 alias read by core 2");
  endtask

  task automatic t_bad_alias;
    logic [31:0] rd; logic er;
    access(1'b1, ra(0, 0), 2'd2, 2'd3, 32'hDEAD, rd, er);
    chk(er === 1'b1, "R4 alias bad core flags error", 32'(er), 32'd1);
    chk(rd === 32'h0, "R4 alias bad core data zero", rd, 32'h0);
    @(posedge clk); @(negedge clk);
    chk(rsp_err === 1'b0, "R4 error lasts one cycle", 32'(rsp_err), 32'd0);
    access(1'b0, ra(0, 0), 2'd2, 2'd3, 32'h0, rd, er);
    chk(er === 1'b1 && rd === 32'h0, "R4 alias bad core read", rd, 32'h0);
    for (int k = 0; k < NC; k++) rd_reg(k + 1, 0, 2'd0, 32'hA0 + 32'(k), "R4 no timer changed");
  endtask

  task automatic t_bad_size;
    logic [31:0] rd; logic er;
    access(1'b1, ra(1, 0), 2'd1, 2'd0, 32'h77, rd, er);
    chk(er === 1'b1, "R5 halfword write flags error", 32'(er), 32'd1);
    access(1'b1, ra(1, 0), 2'd0, 2'd0, 32'h78, rd, er);
    chk(er === 1'b1, "R5 byte write flags error", 32'(er), 32'd1);
    access(1'b0, ra(2, 0) | 8'h1, 2'd2, 2'd0, 32'h0, rd, er);
    chk(er === 1'b1 && rd === 32'h0, "R5 misaligned read", rd, 32'h0);
    rd_reg(1, 0, 2'd0, 32'hA0, "R5 no timer changed");
  endtask

  task automatic t_beyond;
    wr_reg(4, 0, 2'd0, 32'h99, "R6 beyond write no error");
    wr_reg(7, 1, 2'd0, 32'h98, "R6 far window write no error");
    rd_reg(4, 0, 2'd0, 32'h0, "R6 beyond reads zero");
    rd_reg(7, 2, 2'd0, 32'h0, "R6 far window reads zero");
    for (int k = 0; k < NC; k++) rd_reg(k + 1, 0, 2'd0, 32'hA0 + 32'(k), "R6 timers untouched");
  endtask

  task automatic t_expiry;
    wr_reg(2, 0, 2'd0, 32'd5, "R8 load");
    wr_reg(2, 2, 2'd0, 32'h0000_0201, "R8 enable prescale 2");
    repeat (14) @(posedge clk);
    @(negedge clk);
    chk(irq === 3'b000, "R8 no expiry one cycle early", 32'(irq), 32'h0);
    @(posedge clk); @(negedge clk);
    chk(irq === 3'b010, "R8 R12 expiry on core 1 line", 32'(irq), 32'h2);
    rd_reg(2, 1, 2'd0, 32'h0, "R9 one-shot count stays zero");
    rd_reg(2, 3, 2'd0, 32'h1, "R3 status flag set");
    wr_reg(2, 3, 2'd0, 32'h1, "R3 status clear");
    chk(irq === 3'b000, "R3 status clear drops irq", 32'(irq), 32'h0);
  endtask

  task automatic t_reload;
    wr_reg(3, 0, 2'd0, 32'd4, "R9 load");
    wr_reg(3, 2, 2'd0, 32'h0000_0303, "R9 enable autoload prescale 3");
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk(irq[2] === 1'b0, "R8 core 2 not yet expired", 32'(irq[2]), 32'h0);
    @(posedge clk); @(negedge clk);
    chk(irq[2] === 1'b1, "R12 core 2 expired", 32'(irq[2]), 32'h1);
    rd_reg(3, 1, 2'd0, 32'd4, "R9 autoload restores count");
    wr_reg(3, 2, 2'd0, 32'h0, "R9 disable");
    wr_reg(3, 3, 2'd0, 32'h1, "R9 clear");
    chk(irq === 3'b000, "R12 all lines low", 32'(irq), 32'h0);
  endtask

  task automatic t_collide;
    wr_reg(1, 0, 2'd0, 32'd3, "R10 load");
    wr_reg(1, 2, 2'd0, 32'h0000_0101, "R10 enable prescale 1");
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(irq[0] === 1'b0, "R10 not expired before clash", 32'(irq[0]), 32'h0);
    wr_reg(1, 3, 2'd0, 32'h1, "R10 clear on expiry edge");
    chk(irq[0] === 1'b1, "R10 expiry beats clear", 32'(irq[0]), 32'h1);
    wr_reg(1, 3, 2'd0, 32'h1, "R10 later clear");
    chk(irq[0] === 1'b0, "R10 later clear drops irq", 32'(irq[0]), 32'h0);
  endtask

  task automatic t_autostart;
    wr_reg(1, 2, 2'd0, 32'h0, "R11 disable");
    wr_reg(1, 0, 2'd0, 32'd9, "R11 load");
    wr_reg(1, 1, 2'd0, 32'd0, "R11 zero count");
    rd_reg(1, 1, 2'd0, 32'd0, "R11 count is zero");
    wr_reg(1, 2, 2'd0, 32'h0000_F003, "R11 enable with autoload");
    rd_reg(1, 1, 2'd0, 32'd9, "R11 count taken from reload");
    wr_reg(1, 2, 2'd0, 32'h0, "R11 disable again");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_alias();
    t_bad_alias();
    t_bad_size();
    t_beyond();
    t_expiry();
    t_reload();
    t_collide();
    t_autostart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule